// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block turns one 6-bit operand specifier into either a register-operand indication or a 16-bit effective memory address. The specifier carries a 3-bit addressing mode and a 3-bit register number. A byte/word flag sets the operand size. The block reads the selected general register through a read port into an external register file. It makes the memory reads the mode needs over one request/ready port, including a fetch of an index word from the instruction stream. It writes back the register side effects of post-increment and pre-decrement through a one-cycle write port.

A caller pulses `start` with the specifier while the block is idle. A later one-cycle `done` reports the result. With `is_reg` set, the operand is the register itself. Otherwise `ea` holds the operand address. Register 7 serves as the program counter and register 6 as the stack pointer. Apart from the step-size rule below, the block treats both like any other register. Decoding the instruction, the arithmetic and the final operand transfer belong to the surrounding datapath.

Top module: `opspec_addr_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `rf_we` are low and stay low until `start` is seen.
- R2: Mode 0 ends with `done` and `is_reg` = 1, with no memory request and no register write.
- R3: Mode 1 ends with `ea` equal to the register contents, with no memory request and no register write.
- R4: Mode 2 gives `ea` equal to the register contents before the step, and writes the register once with that value plus the step.
- R5: The increment or decrement step is 1 for a byte operand on registers 0 to 5. It is 2 for a word operand, for registers 6 and 7 at any size, and for modes 3 and 5 at any size. Register arithmetic wraps modulo 2^16.
- R6: Mode 3 reads the word at the register contents, gives that word as `ea`, and writes the register once with its value plus 2.
- R7: Mode 4 writes the register once with its value minus the step, and gives that new value as `ea`, with no memory request.
- R8: Mode 5 writes the register once with its value minus 2, reads the word at that new value, and gives the word as `ea`.
- R9: Mode 6 reads the index word at register 7 and writes register 7 once with its old value plus 2. It then gives `ea` = (selected register + index) mod 2^16. When the selected register is register 7, the advanced value is used.
- R10: Mode 7 forms the same sum as mode 6, reads the word at that sum, and gives the word as `ea`.
- R11: `mem_req` stays high with `mem_addr` unchanged until a rising clock edge samples `mem_ready` high. The read data is taken at that edge. `done` is never high together with `mem_req`.
- R12: `done` and `rf_we` are single-cycle pulses. Each operand gives exactly one `done`. Each operand gives exactly one register write per step side effect, and no other write.
- R13: `start` is ignored while a sequence is in progress. No extra `done`, memory request or register write follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence; accepted only when idle |
| spec_mode | input | 3 | Addressing mode 0..7 |
| spec_reg | input | 3 | General register number 0..7 |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| rf_sel | output | 3 | Register-file read select (registered) |
| rf_rdata | input | 16 | Combinational read data for `rf_sel` |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ready | input | 1 | Memory read completes at this edge |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | With `done`: operand is the register itself |
| ea | output | 16 | With `done` and `is_reg` = 0: effective address |

## Verification
Every mode is run on registers whose values make a wrong step, a wrong base or a missed indirection show up as a different address. Byte operands on low registers, on register 6 and on register 7 separate the step of 1 from the forced step of 2. Deferred modes with `byte_op` set show that the forced step of 2 also applies there. Indexed modes on register 7 tell the advanced program counter apart from the stale one. Memory latencies from zero to several cycles, a pre-decrement across zero, and a stray `start` during a long mode 7 sequence cover the handshake, the wrap and the ignore rule.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [2:0] {
    M_REG    = 3'd0,
    M_DEF    = 3'd1,
    M_INC    = 3'd2,
    M_INCDEF = 3'd3,
    M_DEC    = 3'd4,
    M_DECDEF = 3'd5,
    M_IDX    = 3'd6,
    M_IDXDEF = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_IDX,
    ST_IDXW,
    ST_ADD,
    ST_INDW
  } seq_st_e;

endpackage

// File: rtl/opseq_step.sv
module opseq_step #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  opseq_pkg::amode_e mode,
  input  logic [RW-1:0]     rnum,
  input  logic              byte_op,
  output logic [DW-1:0]     step
);
  import opseq_pkg::*;

  localparam logic [RW-1:0] SP_R = RW'(SP_IDX);
  localparam logic [RW-1:0] PC_R = RW'(PC_IDX);

  logic full_step;

  always_comb begin
    full_step = !byte_op || (rnum == SP_R) || (rnum == PC_R) ||
                (mode == M_INCDEF) || (mode == M_DECDEF);
    step      = full_step ? DW'(2) : DW'(1);
  end

endmodule

// File: rtl/opseq_rdport.sv
module opseq_rdport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [DW-1:0] issue_addr,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic          got
);

  assign got = mem_req && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= issue_addr;
    end else if (got) begin
      mem_req  <= 1'b0;
    end
  end

endmodule

// File: rtl/opspec_addr_seq.sv
module opspec_addr_seq #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    spec_mode,
  input  logic [RW-1:0] spec_reg,
  input  logic          byte_op,
  output logic [RW-1:0] rf_sel,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          is_reg,
  output logic [DW-1:0] ea
);
  import opseq_pkg::*;

  localparam logic [RW-1:0] PC_R    = RW'(PC_IDX);
  localparam logic [DW-1:0] PC_STEP = DW'(2);

  seq_st_e       state;
  amode_e        mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] step;
  logic          issue;
  logic [DW-1:0] issue_addr;
  logic          got;

  opseq_step #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_step (
    .mode    (mode_q),
    .rnum    (reg_q),
    .byte_op (byte_q),
    .step    (step)
  );

  opseq_rdport #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (issue_addr),
    .mem_ready  (mem_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .got        (got)
  );

  // Memory read launch: pointer fetch, index fetch, or second-level fetch.
  always_comb begin
    issue      = 1'b0;
    issue_addr = rf_rdata;
    case (state)
      ST_BASE: begin
        if (mode_q == M_INCDEF) begin
          issue      = 1'b1;
          issue_addr = rf_rdata;
        end else if (mode_q == M_DECDEF) begin
          issue      = 1'b1;
          issue_addr = rf_rdata - step;
        end
      end
      ST_IDX: begin
        issue      = 1'b1;
        issue_addr = rf_rdata;
      end
      ST_ADD: begin
        if (mode_q == M_IDXDEF) begin
          issue      = 1'b1;
          issue_addr = rf_rdata + idx_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= M_REG;
      reg_q    <= '0;
      byte_q   <= 1'b0;
      idx_q    <= '0;
      rf_sel   <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      done     <= 1'b0;
      is_reg   <= 1'b0;
      ea       <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= amode_e'(spec_mode);
            reg_q  <= spec_reg;
            byte_q <= byte_op;
            if (spec_mode >= 3'd6) begin
              rf_sel <= PC_R;
              state  <= ST_IDX;
            end else begin
              rf_sel <= spec_reg;
              state  <= ST_BASE;
            end
          end
        end
        ST_BASE: begin
          state <= ST_IDLE;
          case (mode_q)
            M_REG: begin
              done   <= 1'b1;
              is_reg <= 1'b1;
              ea     <= '0;
            end
            M_DEF: begin
              done   <= 1'b1;
              is_reg <= 1'b0;
              ea     <= rf_rdata;
            end
            M_INC: begin
              done     <= 1'b1;
              is_reg   <= 1'b0;
              ea       <= rf_rdata;
              rf_we    <= 1'b1;
              rf_waddr <= reg_q;
              rf_wdata <= rf_rdata + step;
            end
            M_INCDEF: begin
              rf_we    <= 1'b1;
              rf_waddr <= reg_q;
              rf_wdata <= rf_rdata + step;
              state    <= ST_INDW;
            end
            M_DEC: begin
              done     <= 1'b1;
              is_reg   <= 1'b0;
              ea       <= rf_rdata - step;
              rf_we    <= 1'b1;
              rf_waddr <= reg_q;
              rf_wdata <= rf_rdata - step;
            end
            M_DECDEF: begin
              rf_we    <= 1'b1;
              rf_waddr <= reg_q;
              rf_wdata <= rf_rdata - step;
              state    <= ST_INDW;
            end
            default: ;
          endcase
        end
        ST_IDX: begin
          rf_we    <= 1'b1;
          rf_waddr <= PC_R;
          rf_wdata <= rf_rdata + PC_STEP;
          rf_sel   <= reg_q;
          state    <= ST_IDXW;
        end
        ST_IDXW: begin
          if (got) begin
            idx_q <= mem_rdata;
            state <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (mode_q == M_IDX) begin
            done   <= 1'b1;
            is_reg <= 1'b0;
            ea     <= rf_rdata + idx_q;
            state  <= ST_IDLE;
          end else begin
            state <= ST_INDW;
          end
        end
        ST_INDW: begin
          if (got) begin
            done   <= 1'b1;
            is_reg <= 1'b0;
            ea     <= mem_rdata;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          is_reg,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          rf_we
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)        busy_q <= 1'b0;
    else if (done)  busy_q <= start;
    else if (start) busy_q <= 1'b1;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R11
  done_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  // R2
  regop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && is_reg) |-> (!mem_req && !rf_we));

  // R13
  done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_q);

endmodule

bind opspec_addr_seq opseq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .is_reg    (is_reg),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .rf_we     (rf_we)
);

// File: tb/sim_opspec_addr_seq.sv
module sim_opspec_addr_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  spec_mode = '0;
  logic [2:0]  spec_reg = '0;
  logic        byte_op = 1'b0;
  logic [2:0]  rf_sel;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic        is_reg;
  logic [15:0] ea;

  always #4 clk = ~clk;

  opspec_addr_seq u0 (
    .clk(clk), .rst(rst), .start(start), .spec_mode(spec_mode),
    .spec_reg(spec_reg), .byte_op(byte_op), .rf_sel(rf_sel),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done),
    .is_reg(is_reg), .ea(ea)
  );

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  bit finished = 0;

  // Environment register file, loaded by the bench or written by the block.
  logic [15:0] regs [8];
  logic        load_en = 1'b0;
  logic [2:0]  load_idx = '0;
  logic [15:0] load_val = '0;
  assign rf_rdata = regs[rf_sel];

  always @(posedge clk) begin
    if (load_en)    regs[load_idx] <= load_val;
    else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  // Behavioural model state.
  logic [15:0] mregs [8];
  logic [18:0] exp_wr [$];
  logic [15:0] exp_mem [$];
  bit          exp_isreg;
  logic [15:0] exp_ea;
  string       cur_tag = "R1";

  function automatic logic [15:0] md(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'hB3C5;
  endfunction

  // Memory with configurable latency.
  int mem_lat = 0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      if (wcnt >= mem_lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= md(mem_addr);
        wcnt = 0;
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end
  end

  // Per-clock comparison against the model's expected events.
  bit req_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we) begin
        checks++;
        if (exp_wr.size() == 0) begin
          fails++;
          $display("FAIL %s: write reg%0d=%h, expected no write", cur_tag, rf_waddr, rf_wdata);
        end else begin
          logic [18:0] e;
          e = exp_wr.pop_front();
          if ({rf_waddr, rf_wdata} !== e) begin
            fails++;
            $display("FAIL %s: write reg%0d=%h, expected reg%0d=%h",
                     cur_tag, rf_waddr, rf_wdata, e[18:16], e[15:0]);
          end
        end
      end
      if (mem_req && !req_prev) begin
        checks++;
        if (exp_mem.size() == 0) begin
          fails++;
          $display("FAIL %s: read at %h, expected no read", cur_tag, mem_addr);
        end else begin
          logic [15:0] a;
          a = exp_mem.pop_front();
          if (mem_addr !== a) begin
            fails++;
            $display("FAIL %s: read at %h, expected %h", cur_tag, mem_addr, a);
          end
        end
      end
      req_prev = mem_req;
      if (done) begin
        done_cnt++;
        checks++;
        if (is_reg !== exp_isreg || (!exp_isreg && ea !== exp_ea)) begin
          fails++;
          $display("FAIL %s: is_reg=%0b ea=%h, expected is_reg=%0b ea=%h",
                   cur_tag, is_reg, ea, exp_isreg, exp_ea);
        end
      end
    end
  end

  task automatic load_reg(input int i, input logic [15:0] v);
    @(negedge clk);
    load_en = 1'b1; load_idx = 3'(i); load_val = v;
    @(negedge clk);
    load_en = 1'b0;
    mregs[i] = v;
  endtask

  task automatic run_op(input int mode, input int rn, input bit bo,
                        input int lat, input bit stray, input string tag);
    logic [15:0] r, nv, pc, a, stp;
    int d0, n;
    cur_tag = tag;
    mem_lat = lat;
    stp = (mode == 3 || mode == 5 || !bo || rn >= 6) ? 16'd2 : 16'd1;
    r = mregs[rn];
    exp_isreg = 0;
    case (mode)
      0: exp_isreg = 1;
      1: exp_ea = r;
      2: begin exp_ea = r; nv = r + stp; exp_wr.push_back({3'(rn), nv}); mregs[rn] = nv; end
      3: begin exp_mem.push_back(r); exp_ea = md(r);
               exp_wr.push_back({3'(rn), 16'(r + 16'd2)}); mregs[rn] = r + 16'd2; end
      4: begin nv = r - stp; exp_wr.push_back({3'(rn), nv}); mregs[rn] = nv; exp_ea = nv; end
      5: begin nv = r - 16'd2; exp_wr.push_back({3'(rn), nv}); mregs[rn] = nv;
               exp_mem.push_back(nv); exp_ea = md(nv); end
      default: begin
        pc = mregs[7];
        exp_mem.push_back(pc);
        exp_wr.push_back({3'd7, 16'(pc + 16'd2)});
        mregs[7] = pc + 16'd2;
        a = mregs[rn] + md(pc);
        if (mode == 6) exp_ea = a;
        else begin exp_mem.push_back(a); exp_ea = md(a); end
      end
    endcase
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1; spec_mode = 3'(mode); spec_reg = 3'(rn); byte_op = bo;
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      @(negedge clk);
      start = 1'b1; spec_mode = 3'd0; spec_reg = 3'd0; byte_op = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (done_cnt == d0 && n < 200) begin
      @(negedge clk); #1; n++;
    end
    repeat (4) @(negedge clk);
    checks++;
    if (done_cnt != d0 + 1) begin
      fails++;
      $display("FAIL %s (R12): done count %0d, expected 1", tag, done_cnt - d0);
    end
    checks++;
    if (exp_wr.size() != 0 || exp_mem.size() != 0) begin
      fails++;
      $display("FAIL %s (R12): %0d writes and %0d reads missing, expected 0",
               tag, exp_wr.size(), exp_mem.size());
      exp_wr.delete(); exp_mem.delete();
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    load_reg(0, 16'h1000);
    load_reg(1, 16'h2002);
    load_reg(2, 16'h3000);
    load_reg(3, 16'h4006);
    load_reg(4, 16'h5000);
    load_reg(5, 16'h6001);
    load_reg(6, 16'h7FF0);
    load_reg(7, 16'h0100);
    // R1: outputs quiet in and after reset
    repeat (2) @(negedge clk);
    checks++;
    if (done !== 1'b0 || mem_req !== 1'b0 || rf_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: done=%b mem_req=%b rf_we=%b, expected 0 0 0", done, mem_req, rf_we);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || mem_req !== 1'b0 || rf_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: done=%b mem_req=%b rf_we=%b after reset, expected 0 0 0",
               done, mem_req, rf_we);
    end

    run_op(0, 3, 0, 0, 0, "R2");
    run_op(1, 2, 0, 0, 0, "R3");
    run_op(2, 1, 0, 0, 0, "R4");
    run_op(2, 0, 1, 0, 0, "R5");   // byte step 1
    run_op(2, 6, 1, 0, 0, "R5");   // byte on stack pointer: step 2
    run_op(2, 7, 1, 0, 0, "R5");   // byte on program counter: step 2
    run_op(3, 4, 1, 1, 0, "R6");   // deferred forces step 2
    run_op(3, 7, 0, 2, 0, "R6");
    run_op(4, 5, 1, 0, 0, "R7");
    run_op(4, 6, 0, 0, 0, "R7");
    load_reg(0, 16'h0000);
    run_op(4, 0, 1, 0, 0, "R5");   // wrap below zero
    run_op(5, 1, 1, 3, 0, "R8");
    run_op(6, 2, 0, 0, 0, "R9");
    run_op(6, 7, 0, 1, 0, "R9");   // advanced program counter as base
    run_op(7, 3, 0, 0, 0, "R10");
    run_op(7, 7, 1, 4, 0, "R10");
    run_op(1, 5, 0, 5, 0, "R11");
    run_op(5, 6, 0, 5, 0, "R11");
    run_op(7, 1, 0, 3, 1, "R13");  // stray start mid-sequence
    run_op(2, 3, 1, 0, 0, "R13");
    finish_run();
  end

endmodule